// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Engine

This block sits behind a slave-side slot front end of a single-wire serial bus and handles the addressing phase that follows every reset and presence exchange. The front end reports each master write slot as a one-cycle receive strobe carrying the bit value. It reports each master read slot as a one-cycle transmit request, and the engine answers that request in the same cycle with the bit the slave should return. A returned 1 means the line is left released.

The engine owns a 64-bit identity. The low byte is a family code, the next 48 bits are a serial number and the top byte is a check byte. All three come from parameters, and the check byte is computed from the first two at elaboration. After each bus reset the engine collects an 8-bit command. It then carries out one of four ROM functions: read the identity, match the identity, skip addressing, or take part in a bitwise search arbitration. If the function succeeds, it raises `selected` for the function layer above it. If the function fails or the code is unknown, the engine goes quiet until the next bus reset.

Top module: `owrom_engine`

## Requirements
- R1: Before the first `bus_reset` pulse, the engine ignores all write strobes, keeps `selected` low and answers every read request with 1.
- R2: After `bus_reset`, the next eight write strobes form the command code, least significant bit first.
- R3: Command 33h returns the 64 identity bits on the next 64 read requests, least significant bit first: family byte (bits 7:0), serial number (bits 55:8), check byte (bits 63:56). After the 64th bit, `selected` rises.
- R4: Command 55h compares each of the next 64 written bits with the identity bit of the same position, LSB first. The first mismatch ends participation, and `selected` stays low. A full match raises `selected`.
- R5: Command CCh raises `selected` in the cycle after the eighth command bit, with no identity transfer.
- R6: Command F0h runs 64 rounds. In each round the engine answers a read with the identity bit, answers a second read with its complement, then takes one written bit. It continues only if that bit equals its own. After round 64 it raises `selected`.
- R7: After a search mismatch, the engine answers every read with 1 and ignores all writes until the next `bus_reset`.
- R8: `bus_reset` clears `selected` in the following cycle. Otherwise `selected` holds its value, whatever strobes arrive.
- R9: Any command code other than 33h, 55h, CCh and F0h leaves `selected` low. The engine then answers reads with 1 until the next `bus_reset`.
- R10: The check byte is the CRC-8 with polynomial x^8+x^5+x^4+1 (reflected constant 8Ch), starting from zero. It is computed over the 56 bits of family code and serial number, fed LSB first.
- R11: A read request in a phase that expects a write is answered with 1 and does not advance the engine. A write strobe in a phase that expects a read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse when a reset and presence exchange has completed |
| rx_valid | input | 1 | One-cycle strobe: a master write slot has been decoded |
| rx_bit | input | 1 | Bit value of the write slot, valid with `rx_valid` |
| tx_req | input | 1 | One-cycle strobe: a master read slot needs a response bit |
| tx_bit | output | 1 | Response bit for the read slot, valid while `tx_req` is high; 1 means released |
| selected | output | 1 | Device addressed; hand-off to the function layer |

## Verification
The bench goes after mismatches at the first and last identity positions, in both match and search. A design with an off-by-one bit index would either select a device that should have dropped out, or drop one that should stay. The bench sends CCh and expects skip, which catches a design that shifts the command MSB first, because that design would see 33h. It also checks that a losing searcher stays released for the remaining rounds, and that stray strobes of the wrong direction neither advance nor disturb the exchange. The check byte is recomputed with a bit-serial formulation and compared against the last eight bits that a read returns.

// File: rtl/owrom_pkg.sv
package owrom_pkg;
  localparam int FAM_W = 8;
  localparam int SN_W  = 48;
  localparam int CHK_W = 8;
  localparam int ID_W  = FAM_W + SN_W + CHK_W;
  localparam int BODY_W = FAM_W + SN_W;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;

  typedef enum logic [3:0] {
    ST_WAIT, ST_CMD, ST_READ, ST_MATCH,
    ST_SRCH_TRUE, ST_SRCH_COMP, ST_SRCH_ARB,
    ST_DONE, ST_QUIET
  } rom_state_t;

  // Reflected CRC-8 (constant 8Ch), processed byte by byte.
  function automatic logic [CHK_W-1:0] chk_byte(input logic [BODY_W-1:0] body);
    logic [CHK_W-1:0] acc;
    logic [7:0]       cur;
    acc = '0;
    for (int b = 0; b < BODY_W / 8; b++) begin
      cur = body[b*8 +: 8];
      for (int j = 0; j < 8; j++) begin
        if (acc[0] ^ cur[0]) acc = (acc >> 1) ^ 8'h8C;
        else                 acc = acc >> 1;
        cur = cur >> 1;
      end
    end
    return acc;
  endfunction
endpackage

// File: rtl/owrom_id.sv
module owrom_id
  import owrom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h3C,
  parameter logic [SN_W-1:0]  SERIAL = 48'h00A5_C31E_7709,
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic [IDX_W-1:0] idx,
  output logic             id_bit
);
  localparam logic [BODY_W-1:0] BODY = {SERIAL, FAMILY};
  localparam logic [ID_W-1:0]   IDENT = {chk_byte(BODY), BODY};

  assign id_bit = IDENT[idx];
endmodule

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx
  import owrom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift_en,
  input  logic       bit_in,
  output logic       cmd_done,
  output logic [7:0] cmd_full
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;

  assign cmd_done = shift_en && (cnt_q == 3'd7);
  assign cmd_full = {bit_in, sh_q[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= {bit_in, sh_q[7:1]};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  AST_CMD_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == 3'd0)) else $error("count not cleared"); // R2
endmodule

// File: rtl/owrom_engine.sv
module owrom_engine
  import owrom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h3C,
  parameter logic [SN_W-1:0]  SERIAL = 48'h00A5_C31E_7709
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_req,
  output logic tx_bit,
  output logic selected
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

  rom_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sel_q, sel_d;

  logic       id_bit;
  logic       last_bit;
  logic       bit_miss;
  logic       cmd_done;
  logic [7:0] cmd_full;
  logic       cmd_shift;

  owrom_id #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
    .idx    (idx_q),
    .id_bit (id_bit)
  );

  assign cmd_shift = rx_valid && (state_q == ST_CMD) && !bus_reset;

  owrom_cmd_rx u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (bus_reset),
    .shift_en (cmd_shift),
    .bit_in   (rx_bit),
    .cmd_done (cmd_done),
    .cmd_full (cmd_full)
  );

  assign last_bit = (idx_q == LAST_IDX);
  assign bit_miss = rx_bit != id_bit;

  always_comb begin
    case (state_q)
      ST_READ, ST_SRCH_TRUE: tx_bit = id_bit;
      ST_SRCH_COMP:          tx_bit = ~id_bit;
      default:               tx_bit = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sel_d   = sel_q;
    if (bus_reset) begin
      state_d = ST_CMD;
      idx_d   = '0;
      sel_d   = 1'b0;
    end else begin
      case (state_q)
        ST_CMD: if (cmd_done) begin
          case (cmd_full)
            CMD_READ:   state_d = ST_READ;
            CMD_MATCH:  state_d = ST_MATCH;
            CMD_SEARCH: state_d = ST_SRCH_TRUE;
            CMD_SKIP: begin
              state_d = ST_DONE;
              sel_d   = 1'b1;
            end
            default:    state_d = ST_QUIET;
          endcase
        end
        ST_READ: if (tx_req) begin
          if (last_bit) begin
            state_d = ST_DONE;
            sel_d   = 1'b1;
          end else idx_d = idx_q + 1'b1;
        end
        ST_MATCH, ST_SRCH_ARB: if (rx_valid) begin
          if (bit_miss) state_d = ST_QUIET;
          else if (last_bit) begin
            state_d = ST_DONE;
            sel_d   = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
            if (state_q == ST_SRCH_ARB) state_d = ST_SRCH_TRUE;
          end
        end
        ST_SRCH_TRUE: if (tx_req) state_d = ST_SRCH_COMP;
        ST_SRCH_COMP: if (tx_req) state_d = ST_SRCH_ARB;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      idx_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sel_q   <= sel_d;
    end
  end

  assign selected = sel_q;

  AST_CMD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD || state_q == ST_WAIT) |-> tx_bit) else $error("drive in cmd"); // R11
  AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !selected) else $error("selected kept"); // R8
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_reset) |=> selected) else $error("selected dropped"); // R8
  AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUIET && !bus_reset) |=> (state_q == ST_QUIET)) else $error("left quiet"); // R7
  AST_MISS_QUITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MATCH && rx_valid && bit_miss && !bus_reset) |=> !selected && state_q == ST_QUIET)
    else $error("match miss ignored"); // R4
  AST_COMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRCH_COMP) |-> ($past(state_q) == ST_SRCH_TRUE || $past(state_q) == ST_SRCH_COMP))
    else $error("search order"); // R6
  AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !selected) else $error("selected pre reset"); // R1
endmodule

// File: tb/sim_owrom_engine.sv
module sim_owrom_engine;
  localparam logic [7:0]  FAM = 8'h3C;
  localparam logic [47:0] SN  = 48'h00A5_C31E_7709;

  // {cmd[23:16], op[15:12], pos[11:4], 3'b0, exp_sel}
  // op: 0 read, 1 match (flip at pos, 64 = none), 2 nothing more, 3 search (flip at pos)
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'h33, 4'd0, 8'd0,  4'd1},
    {8'h55, 4'd1, 8'd64, 4'd1},
    {8'h55, 4'd1, 8'd0,  4'd0},
    {8'h55, 4'd1, 8'd63, 4'd0},
    {8'h55, 4'd1, 8'd17, 4'd0},
    {8'hCC, 4'd2, 8'd0,  4'd1},
    {8'hF0, 4'd3, 8'd64, 4'd1},
    {8'hF0, 4'd3, 8'd0,  4'd0},
    {8'hF0, 4'd3, 8'd5,  4'd0},
    {8'hF0, 4'd3, 8'd63, 4'd0},
    {8'hA5, 4'd2, 8'd0,  4'd0},
    {8'h0F, 4'd2, 8'd0,  4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic tx_bit, selected;
  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_id;

  always #4 clk = ~clk;

  owrom_engine #(.FAMILY(FAM), .SERIAL(SN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected)
  );

  function automatic logic [7:0] crc_serial(input logic [55:0] stream);
    logic [7:0] r = 8'h00;
    logic fb;
    for (int i = 0; i < 56; i++) begin
      fb = r[0] ^ stream[i];
      r = {fb, r[7:1]};
      r[3] = r[3] ^ fb;
      r[2] = r[2] ^ fb;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic wr(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rd(output logic b);
    @(negedge clk); tx_req = 1'b1; #1 b = tx_bit;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic b, b2;
    logic [63:0] got;
    int errs;
    exp_id = {crc_serial({SN, FAM}), SN, FAM};
    repeat (3) @(negedge clk);
    // R1 / R8: reset state
    #1 chk("R8 reset selected", 64'(selected), 64'd0);
    chk("R1 reset tx", 64'(tx_bit), 64'd1);
    rst_n = 1'b1;
    // R1: skip before any bus reset is ignored
    send_cmd(8'hCC);
    chk("R1 cmd before reset", 64'(selected), 64'd0);
    rd(b);
    chk("R1 read before reset", 64'(b), 64'd1);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd = VEC[v][23:16];
      logic [3:0] op  = VEC[v][15:12];
      int         pos = int'(VEC[v][11:4]);
      logic       es  = VEC[v][0];
      pulse_reset();
      send_cmd(cmd);
      case (op)
        4'd0: begin // R3 read, R10 check byte
          for (int i = 0; i < 64; i++) begin rd(b); got[i] = b; end
          chk("R3 read stream", got, exp_id);
          chk("R10 check byte", 64'(got[63:56]), 64'(crc_serial({SN, FAM})));
        end
        4'd1: begin // R4 match
          for (int i = 0; i < 64; i++) wr(exp_id[i] ^ (i == pos));
          if (pos < 64) begin
            rd(b);
            chk("R4 released after miss", 64'(b), 64'd1);
          end
        end
        4'd3: begin // R6 search, R7 loser
          errs = 0;
          for (int i = 0; i < 64; i++) begin
            rd(b); rd(b2);
            if (i <= pos) begin
              if (b !== exp_id[i] || b2 !== ~exp_id[i]) errs++;
            end else if (b !== 1'b1 || b2 !== 1'b1) errs++;
            wr(exp_id[i] ^ (i == pos));
          end
          chk(pos < 64 ? "R7 search drop-out" : "R6 search rounds", 64'(errs), 64'd0);
        end
        default: ;
      endcase
      // R5 skip, R9 unknown, R4/R6 final state
      chk(op == 4'd2 ? (es ? "R5 skip" : "R9 unknown code") : "R4 R6 select result",
          64'(selected), 64'(es));
    end

    // R8: selection held through stray strobes, cleared by reset
    pulse_reset(); send_cmd(8'hCC);
    send_cmd(8'h55); rd(b);
    chk("R8 held", 64'(selected), 64'd1);
    chk("R8 released tx", 64'(b), 64'd1);
    pulse_reset();
    chk("R8 cleared", 64'(selected), 64'd0);
    // R2: MSB-first would decode CCh as 33h and stream the ID
    send_cmd(8'hCC);
    chk("R2 lsb first", 64'(selected), 64'd1);
    // R11: wrong-direction strobes ignored
    pulse_reset(); send_cmd(8'hF0);
    wr(~exp_id[0]);
    rd(b); rd(b2);
    chk("R11 write in tx phase", {62'd0, b, b2}, {62'd0, exp_id[0], ~exp_id[0]});
    rd(b);
    chk("R11 read in rx phase", 64'(b), 64'd1);
    wr(exp_id[0]);
    rd(b);
    chk("R11 search continues", 64'(b), 64'(exp_id[1]));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule